// File: doc/BRIEF.md
# Cache line refill sequencer

This block brings one whole cache line in from a 64-bit pipelined bus after a miss. A miss request supplies the real address that missed and the way chosen as victim. The sequencer then issues one bus read per row of the line. It starts at the row that missed and steps only the row-within-line address field, so the sequence wraps inside the line and ends after every row has been requested once.

Requests and acknowledges are tracked separately. A small counter holds the number of reads that are accepted but not yet answered, and new requests stop while that counter is full. Each returning row produces one write to the cache data memory at the row number of the way being filled, and sets that row's flag in a per-row valid vector. The tag for the line is published as a one-cycle strobe when the refill starts. The valid-bit update for the line is a one-cycle strobe when the last row lands. Hit detection, translation, victim choice and stores are handled elsewhere.

Top module: `refill_seq`

## Requirements
- R1: After reset, bus_cyc, bus_stb, busy, tag_we, valid_we, mem_we and line_done are 0, row_valid is all zeros, and no acknowledge is counted as outstanding.
- R2: A miss is taken only while busy is 0. The cycle after a taken miss, busy, bus_cyc and bus_stb are 1, bus_sel is all ones, and bus_adr is the miss address with its low 3 bits cleared. A miss presented while busy is 1 is ignored and does not change the request sequence.
- R3: tag_we is high for exactly the one cycle after a taken miss. In that cycle fill_tag holds address bits 31..10, fill_index holds address bits 9..6, and fill_way holds the victim way. tag_we is 0 at all other times.
- R4: A request is accepted on a clock edge where bus_stb is 1 and bus_stall is 0. After an accepted request that is not the last one, bus_adr keeps bits 31..6 and bits 2..0 and adds one, modulo 8, to bits 5..3. While the request is stalled, bus_adr holds its value.
- R5: Exactly 8 requests are accepted per refill. The first has the miss row in bits 5..3, and later ones wrap through the line. bus_stb is 0 from the cycle after the eighth acceptance onward, and bus_stb is only ever 1 while bus_cyc is 1.
- R6: At most 7 requests are outstanding. In any cycle where 7 accepted requests have no acknowledge yet, bus_stb is 0. Issue resumes after an acknowledge.
- R7: Every bus_ack while bus_cyc is 1 gives mem_we = 1 in the next cycle. mem_wdata carries the bus data, and mem_way carries the victim way. mem_row is {address bits 9..6, row-in-line}, with the row-in-line starting at the miss row and rising by one modulo 8 per acknowledge.
- R8: row_valid is cleared when a miss is taken. Bit k becomes 1 in the cycle after the acknowledge that delivers row-in-line k.
- R9: In the cycle after the acknowledge of the final row, which leaves nothing outstanding, line_done and valid_we are high for one cycle, with fill_index and fill_way still identifying the line. In that same cycle busy and bus_cyc are 0, and a new miss can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | 32 | Real byte address that missed |
| miss_way | input | 1 | Victim way to refill |
| busy | output | 1 | Refill in progress |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Read request valid |
| bus_adr | output | 32 | Read request byte address |
| bus_sel | output | 8 | Byte selects, all ones |
| bus_stall | input | 1 | Slave cannot accept a request |
| bus_ack | input | 1 | Read data valid |
| bus_dat_i | input | 64 | Read data |
| mem_we | output | 1 | Data memory write strobe |
| mem_way | output | 1 | Way written |
| mem_row | output | 7 | Data memory row {index, row-in-line} |
| mem_wdata | output | 64 | Data memory write data |
| row_valid | output | 8 | Per-row arrival flags |
| tag_we | output | 1 | Tag write strobe |
| valid_we | output | 1 | Line valid-bit set strobe |
| fill_index | output | 4 | Line index of the refill |
| fill_way | output | 1 | Way of the refill |
| fill_tag | output | 22 | Tag of the refill |
| line_done | output | 1 | Line complete pulse |

## Verification
Every result has a fixed latency of one cycle after the edge that causes it. The first request, busy and the tag strobe appear one cycle after the miss is taken. A data memory write and its row flag appear one cycle after an acknowledge. The completion strobes appear one cycle after the final acknowledge. The drop of bus_stb appears one cycle after the acceptance that fills the request cap or issues the last row. The bench drives the bus on the falling edge and predicts, at that moment, what the next rising edge will accept or acknowledge. It then checks each effect at the following falling edge, so every comparison falls exactly one register stage after its cause.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int BUS_DATA_W = 64;
  localparam int BUS_SEL_W  = 8;

  typedef enum logic {
    FILL_IDLE,
    FILL_RUN
  } fill_state_e;
endpackage

// File: rtl/rl_field_inc.sv
// Narrow incrementer: adds one to a field of FW bits at offset LO,
// leaving all other bits of the word untouched (wraps inside the field).
module rl_field_inc #(
  parameter int W  = 32,
  parameter int LO = 3,
  parameter int FW = 3
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_comb begin
    dout = din;
    dout[LO +: FW] = din[LO +: FW] + 1'b1;
  end
endmodule

// File: rtl/rl_req_issue.sv
// Request side: bus address stepping and outstanding-acknowledge count.
module rl_req_issue #(
  parameter int ADDR_W = 32,
  parameter int ROW_OFF_BITS = 3,
  parameter int ROW_LINE_BITS = 3,
  parameter int CNT_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_adr,
  input  logic [ROW_LINE_BITS-1:0] end_row,
  input  logic                     stall,
  input  logic                     ack_seen,
  output logic                     stb,
  output logic [ADDR_W-1:0]        adr,
  output logic [CNT_W-1:0]         outstanding
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              req_done_q;
  logic              accept, last_req, done_next;
  logic [CNT_W-1:0]  cnt_next;
  logic [ADDR_W-1:0] adr_inc;

  rl_field_inc #(.W(ADDR_W), .LO(ROW_OFF_BITS), .FW(ROW_LINE_BITS)) u_adr_inc (
    .din (adr),
    .dout(adr_inc)
  );

  assign accept    = stb && !stall;
  assign last_req  = adr[ROW_OFF_BITS +: ROW_LINE_BITS] == end_row;
  assign done_next = req_done_q || (accept && last_req);
  assign cnt_next  = outstanding + {{(CNT_W-1){1'b0}}, accept}
                                 - {{(CNT_W-1){1'b0}}, ack_seen};

  always_ff @(posedge clk) begin
    if (rst) begin
      stb         <= 1'b0;
      adr         <= '0;
      outstanding <= '0;
      req_done_q  <= 1'b1;
    end else if (start) begin
      stb         <= 1'b1;
      adr         <= start_adr;
      outstanding <= '0;
      req_done_q  <= 1'b0;
    end else begin
      outstanding <= cnt_next;
      req_done_q  <= done_next;
      stb         <= !done_next && (cnt_next != CNT_MAX);
      if (accept && !last_req) adr <= adr_inc;
    end
  end

  p_cnt_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (outstanding == CNT_MAX) |-> !stb);
  p_adr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stb && stall && !start) |=> $stable(adr));
  p_adr_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !start) |=> (adr[ADDR_W-1:ROW_OFF_BITS+ROW_LINE_BITS]
                            == $past(adr[ADDR_W-1:ROW_OFF_BITS+ROW_LINE_BITS])));
endmodule

// File: rtl/rl_data_return.sv
// Return side: data memory row stepping, per-row valid flags, write port.
module rl_data_return #(
  parameter int ROW_BITS = 7,
  parameter int ROW_LINE_BITS = 3,
  parameter int DATA_W = 64,
  localparam int ROWS = 1 << ROW_LINE_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ROW_BITS-1:0]      start_row,
  input  logic [ROW_LINE_BITS-1:0] end_row,
  input  logic                     ack_seen,
  input  logic [DATA_W-1:0]        ack_data,
  output logic                     last_row,
  output logic                     mem_we,
  output logic [ROW_BITS-1:0]      mem_row,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [ROWS-1:0]          row_valid
);
  logic [ROW_BITS-1:0] row_q, row_inc;

  rl_field_inc #(.W(ROW_BITS), .LO(0), .FW(ROW_LINE_BITS)) u_row_inc (
    .din (row_q),
    .dout(row_inc)
  );

  assign last_row = row_q[ROW_LINE_BITS-1:0] == end_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      row_valid <= '0;
      row_q     <= '0;
    end else if (start) begin
      mem_we    <= 1'b0;
      row_valid <= '0;
      row_q     <= start_row;
    end else begin
      mem_we <= ack_seen;
      if (ack_seen) begin
        row_valid[row_q[ROW_LINE_BITS-1:0]] <= 1'b1;
        row_q <= row_inc;
      end
    end
  end

  // Write-port datapath carries no reset, as a block RAM port would.
  always_ff @(posedge clk) begin
    if (ack_seen) begin
      mem_row   <= row_q;
      mem_wdata <= ack_data;
    end
  end

  p_write_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_seen && !start) |=> mem_we);
  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (row_valid == '0));
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_OFF_BITS = 3,
  parameter int LINE_OFF_BITS = 6,
  parameter int SET_SIZE_BITS = 10,
  parameter int NUM_WAYS = 2,
  parameter int CNT_W = 3,
  parameter int DATA_W = BUS_DATA_W,
  localparam int ROW_LINE_BITS = LINE_OFF_BITS - ROW_OFF_BITS,
  localparam int ROWS = 1 << ROW_LINE_BITS,
  localparam int INDEX_BITS = SET_SIZE_BITS - LINE_OFF_BITS,
  localparam int ROW_BITS = SET_SIZE_BITS - ROW_OFF_BITS,
  localparam int TAG_BITS = ADDR_W - SET_SIZE_BITS,
  localparam int WAY_BITS = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  input  logic [ADDR_W-1:0]     miss_addr,
  input  logic [WAY_BITS-1:0]   miss_way,
  output logic                  busy,
  output logic                  bus_cyc,
  output logic                  bus_stb,
  output logic [ADDR_W-1:0]     bus_adr,
  output logic [SEL_W-1:0]      bus_sel,
  input  logic                  bus_stall,
  input  logic                  bus_ack,
  input  logic [DATA_W-1:0]     bus_dat_i,
  output logic                  mem_we,
  output logic [WAY_BITS-1:0]   mem_way,
  output logic [ROW_BITS-1:0]   mem_row,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [ROWS-1:0]       row_valid,
  output logic                  tag_we,
  output logic                  valid_we,
  output logic [INDEX_BITS-1:0] fill_index,
  output logic [WAY_BITS-1:0]   fill_way,
  output logic [TAG_BITS-1:0]   fill_tag,
  output logic                  line_done
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  if (DATA_W != BUS_DATA_W || SEL_W != BUS_SEL_W) begin : g_bad_width
    $error("refill_seq: bus data width must be 64 bits");
  end

  fill_state_e              state_q;
  logic                     start, ack_seen, fin, last_row;
  logic [CNT_W-1:0]         outstanding;
  logic [ROW_LINE_BITS-1:0] end_row_q;
  logic [ADDR_W-1:0]        start_adr;

  assign start    = (state_q == FILL_IDLE) && miss_valid;
  assign ack_seen = bus_ack && bus_cyc;
  assign fin      = ack_seen && last_row && (outstanding == CNT_ONE);
  assign busy     = state_q == FILL_RUN;
  assign bus_sel  = '1;
  assign mem_way  = fill_way;

  always_comb begin
    start_adr = miss_addr;
    start_adr[ROW_OFF_BITS-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FILL_IDLE;
      bus_cyc    <= 1'b0;
      tag_we     <= 1'b0;
      valid_we   <= 1'b0;
      line_done  <= 1'b0;
      end_row_q  <= '0;
      fill_index <= '0;
      fill_way   <= '0;
      fill_tag   <= '0;
    end else begin
      tag_we    <= start;
      valid_we  <= fin;
      line_done <= fin;
      if (start) begin
        state_q    <= FILL_RUN;
        bus_cyc    <= 1'b1;
        // The row before the first one is the last to be requested.
        end_row_q  <= miss_addr[LINE_OFF_BITS-1:ROW_OFF_BITS] - 1'b1;
        fill_index <= miss_addr[SET_SIZE_BITS-1:LINE_OFF_BITS];
        fill_way   <= miss_way;
        fill_tag   <= miss_addr[ADDR_W-1:SET_SIZE_BITS];
      end else if (fin) begin
        state_q <= FILL_IDLE;
        bus_cyc <= 1'b0;
      end
    end
  end

  rl_req_issue #(
    .ADDR_W(ADDR_W), .ROW_OFF_BITS(ROW_OFF_BITS),
    .ROW_LINE_BITS(ROW_LINE_BITS), .CNT_W(CNT_W)
  ) u_req (
    .clk(clk), .rst(rst), .start(start), .start_adr(start_adr),
    .end_row(end_row_q), .stall(bus_stall), .ack_seen(ack_seen),
    .stb(bus_stb), .adr(bus_adr), .outstanding(outstanding)
  );

  rl_data_return #(
    .ROW_BITS(ROW_BITS), .ROW_LINE_BITS(ROW_LINE_BITS), .DATA_W(DATA_W)
  ) u_ret (
    .clk(clk), .rst(rst), .start(start),
    .start_row(miss_addr[SET_SIZE_BITS-1:ROW_OFF_BITS]),
    .end_row(end_row_q), .ack_seen(ack_seen), .ack_data(bus_dat_i),
    .last_row(last_row), .mem_we(mem_we), .mem_row(mem_row),
    .mem_wdata(mem_wdata), .row_valid(row_valid)
  );

  p_stb_in_cyc_r5: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_cyc);
  p_tag_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tag_we |=> !tag_we);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (!busy && !bus_cyc && valid_we));
  p_busy_ignores_miss_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && miss_valid) |=> !tag_we);
endmodule

// File: tb/tb_refill_seq.sv
module tb_refill_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic [0:0]  miss_way;
  logic        busy, bus_cyc, bus_stb;
  logic [31:0] bus_adr;
  logic [7:0]  bus_sel;
  logic        bus_stall, bus_ack;
  logic [63:0] bus_dat_i;
  logic        mem_we;
  logic [0:0]  mem_way;
  logic [6:0]  mem_row;
  logic [63:0] mem_wdata;
  logic [7:0]  row_valid;
  logic        tag_we, valid_we;
  logic [3:0]  fill_index;
  logic [0:0]  fill_way;
  logic [21:0] fill_tag;
  logic        line_done;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  refill_seq dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_adr(input logic [31:0] a, input int k);
    logic [2:0] r;
    r = a[5:3] + 3'(k);
    return {a[31:6], r, 3'b000};
  endfunction

  function automatic logic [6:0] exp_row(input logic [31:0] a, input int k);
    logic [2:0] r;
    r = a[5:3] + 3'(k);
    return {a[9:6], r};
  endfunction

  function automatic logic [63:0] dat_of(input logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, ~a};
  endfunction

  task automatic run_refill(input logic [31:0] a, input logic w,
                            input int stall_pct, input int ack_pct,
                            input bit hold, input bit poke);
    int nreq = 0, nack = 0, pend_k = 0;
    bit pend = 0, released = !hold, done_seen = 0, stall_b, ack_b;
    logic [7:0] mask = '0;
    logic [2:0] rk;
    miss_valid = 1'b1; miss_addr = a; miss_way = w;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy && bus_cyc && bus_stb, "R2", "busy/cyc/stb after miss",
        {busy, bus_cyc, bus_stb}, 3'b111);
    chk(bus_adr == exp_adr(a, 0), "R2", "first address", bus_adr, exp_adr(a, 0));
    chk(bus_sel == 8'hFF, "R2", "byte selects", bus_sel, 8'hFF);
    chk(tag_we && fill_tag == a[31:10] && fill_index == a[9:6] && fill_way == w,
        "R3", "tag strobe and fields", {tag_we, fill_tag, fill_index, fill_way},
        {1'b1, a[31:10], a[9:6], w});
    chk(row_valid == 8'h00, "R8", "row flags cleared at start", row_valid, 0);
    for (int cyc_i = 0; cyc_i < 600; cyc_i++) begin
      if (pend) begin
        chk(mem_we == 1'b1, "R7", "write after ack", mem_we, 1);
        chk(mem_row == exp_row(a, pend_k), "R7", "write row", mem_row, exp_row(a, pend_k));
        chk(mem_wdata == dat_of(exp_adr(a, pend_k)), "R7", "write data",
            mem_wdata, dat_of(exp_adr(a, pend_k)));
        chk(mem_way == w, "R7", "write way", mem_way, w);
        rk = a[5:3] + 3'(pend_k);
        mask[rk] = 1'b1;
        chk(row_valid == mask, "R8", "row flags", row_valid, mask);
      end else if (cyc_i > 0) begin
        chk(mem_we == 1'b0, "R7", "no write without ack", mem_we, 0);
      end
      if (pend && nack == 8) begin
        chk(line_done && valid_we, "R9", "done strobes", {line_done, valid_we}, 2'b11);
        chk(fill_index == a[9:6] && fill_way == w, "R9", "valid-set target",
            {fill_index, fill_way}, {a[9:6], w});
        chk(!busy && !bus_cyc, "R9", "idle after done", {busy, bus_cyc}, 0);
        done_seen = 1;
        break;
      end
      chk(line_done == 1'b0, "R9", "no early done", line_done, 0);
      if (cyc_i > 0) chk(tag_we == 1'b0, "R3", "tag strobe single", tag_we, 0);
      if (nreq - nack == 7) begin
        chk(bus_stb == 1'b0, "R6", "stb low at cap", bus_stb, 0);
        released = 1;
      end
      if (nreq == 8) chk(bus_stb == 1'b0, "R5", "stb low after last", bus_stb, 0);
      miss_valid = poke && (nreq == 3);
      miss_addr  = ~a;
      stall_b = $urandom_range(99) < stall_pct;
      if (!released && nreq < 8) ack_b = 1'b0;
      else ack_b = (nreq > nack) && ($urandom_range(99) < ack_pct);
      bus_stall = stall_b;
      bus_ack   = ack_b;
      bus_dat_i = ack_b ? dat_of(exp_adr(a, nack)) : 64'h0;
      if (bus_cyc && bus_stb && !stall_b) begin
        chk(bus_adr == exp_adr(a, nreq), "R4", "request address", bus_adr, exp_adr(a, nreq));
        nreq++;
      end
      if (ack_b) begin pend = 1; pend_k = nack; nack++; end
      else pend = 0;
      @(negedge clk);
    end
    chk(done_seen, "R9", "line completed", done_seen, 1);
    chk(nreq == 8, "R5", "request count", nreq, 8);
    miss_valid = 1'b0; bus_ack = 1'b0; bus_stall = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; miss_valid = 1'b0; miss_addr = '0; miss_way = '0;
    bus_stall = 1'b0; bus_ack = 1'b0; bus_dat_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_cyc && !bus_stb && !busy, "R1", "bus idle after reset",
        {bus_cyc, bus_stb, busy}, 0);
    chk(!tag_we && !valid_we && !mem_we && !line_done, "R1", "strobes low after reset",
        {tag_we, valid_we, mem_we, line_done}, 0);
    chk(row_valid == 8'h00, "R1", "row flags after reset", row_valid, 0);
    run_refill(32'h1234_5640, 1'b0, 0, 100, 0, 0);   // line-aligned, fast bus
    run_refill(32'hABCD_E3EC, 1'b1, 20, 60, 0, 0);   // mid-line start, wraps
    run_refill(32'h0000_0038, 1'b0, 10, 80, 1, 0);   // acks withheld: cap (R6)
    run_refill(32'hFFFF_FFC8, 1'b1, 30, 50, 0, 1);   // miss while busy (R2)
    run_refill(32'h5555_5578, 1'b0, 70, 30, 0, 0);   // heavy stall
    for (int i = 0; i < 30; i++)
      run_refill($urandom, 1'($urandom_range(1)), $urandom_range(60),
                 20 + $urandom_range(80), $urandom_range(3) == 0, $urandom_range(3) == 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule